// File: doc/BRIEF.md
# GPIO Port Register File

This block is the register side of a 32-pin general purpose I/O port. A simple 32-bit memory-mapped bus reads and writes an output latch, a direction latch, a sampled input word and one configuration word per pin. The output and direction latches each have three write addresses: a plain write, a set alias and a clear alias. Only aligned 32-bit word accesses are decoded, with little-endian byte order.

The latch and configuration values go straight to a per-pin pad resolver. The resolved input word comes back from that resolver and is sampled every clock. A pin's direction can be written through the shared direction register or through bit 0 of that pin's configuration word. Both views always agree, because they share a single storage bit.

Any access to an unmapped or misaligned offset has no effect and raises a one-cycle `bad_access` pulse. Read data returns one cycle after the request.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the output latch, the direction latch and the sampled input word are 0, and every configuration word reads 0x00000002.
- R2: A write to offset 0x504 replaces the output latch. A read of 0x504, 0x508 or 0x50C returns the output latch.
- R3: A write to 0x508 ORs the data into the output latch. A write to 0x50C clears every latch bit that is 1 in the data.
- R4: Offsets 0x514 (replace), 0x518 (set) and 0x51C (clear) apply the same rules to the direction latch. A read of any of the three returns the direction latch.
- R5: After any write to 0x514, 0x518 or 0x51C, bit 0 of configuration word i equals direction bit i from the next cycle on.
- R6: A write to configuration word i at offset 0x700 + 4*i (pins 0 to 31, up to 0x77C) stores the word. Bit 0 of the written data becomes direction bit i, and the other direction bits are unchanged. A read of that offset returns the stored word.
- R7: The input word at 0x510 samples `pad_in` on every clock edge. A read returns the value captured at the edge before the request. A write to 0x510 has no effect and is not a bad access.
- R8: A read of an unmapped or misaligned offset returns 0. A write to one changes no state. In both cases `bad_access` is 1 for exactly the cycle after the request.
- R9: `rsp_valid` is 1 for one cycle after each read request, with `rsp_rdata` valid in that cycle. A write produces no response.
- R10: `pad_out`, `pad_dir` and `pad_cfg` (word i at bits 32*i+31 down to 32*i) show the latch values from the edge that performed the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| bad_access | output | 1 | One-cycle pulse after an unmapped or misaligned access |
| pad_in | input | 32 | Resolved input word from the pad resolver |
| pad_out | output | 32 | Output latch to the pad resolver |
| pad_dir | output | 32 | Direction latch to the pad resolver |
| pad_cfg | output | 1024 | All 32 configuration words, pin i at bits 32*i+31 down to 32*i |

## Verification
Input sampling and a bus read of the input word can fall on the same edge. The bench changes `pad_in` in the very cycle it issues a read of 0x510. It expects the response to carry the word captured one edge earlier, and a second read to show the new word. The direction latch is the other point where two paths meet: an alias write and a configuration-word write both reach the same bits. The bench alternates the two and expects the direction reads and the configuration reads to stay in agreement after each one.

// File: rtl/gpio_rf_pkg.sv
// Shared offsets and types for the GPIO port register file.
// Assumes a 12-bit byte offset and 32-bit data words.
package gpio_rf_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_OUT    = 12'h504;
    localparam logic [ADDR_W-1:0] OFF_OUTSET = 12'h508;
    localparam logic [ADDR_W-1:0] OFF_OUTCLR = 12'h50C;
    localparam logic [ADDR_W-1:0] OFF_IN     = 12'h510;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h514;
    localparam logic [ADDR_W-1:0] OFF_DIRSET = 12'h518;
    localparam logic [ADDR_W-1:0] OFF_DIRCLR = 12'h51C;
    localparam logic [ADDR_W-1:0] OFF_CFG0   = 12'h700;

    localparam logic [DATA_W-1:0] CFG_RESET  = 32'h0000_0002;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_OUT,
        TGT_IN,
        TGT_DIR,
        TGT_CFG
    } tgt_e;

    typedef enum logic [1:0] {
        OP_REPLACE,
        OP_SET,
        OP_CLR
    } wop_e;
endpackage

// File: rtl/gpio_rf_decode.sv
// Address decoder: maps a byte offset to a target register, a write
// operation (replace, set or clear) and a configuration pin index.
// Assumes word-aligned accesses; a misaligned offset decodes as no hit.
module gpio_rf_decode
    import gpio_rf_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic [ADDR_W-1:0]          addr,
    output tgt_e                       tgt,
    output wop_e                       op,
    output logic [$clog2(NPINS)-1:0]   pidx,
    output logic                       hit
);
    localparam int unsigned PIDX_W   = $clog2(NPINS);
    localparam int unsigned CFG_SPAN = 4 * NPINS;

    logic [ADDR_W-1:0] cfg_off;
    logic              aligned;
    logic              in_cfg;

    assign cfg_off = addr - OFF_CFG0;
    assign aligned = (addr[1:0] == 2'b00);
    assign in_cfg  = aligned && (addr >= OFF_CFG0) && (cfg_off < ADDR_W'(CFG_SPAN));
    assign pidx    = PIDX_W'(cfg_off >> 2);

    // Classify the offset into a target and an operation.
    always_comb begin
        tgt = TGT_NONE;
        op  = OP_REPLACE;
        if (in_cfg) begin
            tgt = TGT_CFG;
        end else if (aligned) begin
            unique case (addr)
                OFF_OUT:    begin tgt = TGT_OUT; op = OP_REPLACE; end
                OFF_OUTSET: begin tgt = TGT_OUT; op = OP_SET;     end
                OFF_OUTCLR: begin tgt = TGT_OUT; op = OP_CLR;     end
                OFF_IN:     begin tgt = TGT_IN;                   end
                OFF_DIR:    begin tgt = TGT_DIR; op = OP_REPLACE; end
                OFF_DIRSET: begin tgt = TGT_DIR; op = OP_SET;     end
                OFF_DIRCLR: begin tgt = TGT_DIR; op = OP_CLR;     end
                default:    begin tgt = TGT_NONE;                 end
            endcase
        end
    end

    assign hit = (tgt != TGT_NONE);
endmodule

// File: rtl/gpio_rf_latch.sv
// Word latch with replace, set and clear writes plus a single-bit
// load port. Assumes the word write and the bit load never coincide
// (one bus request per cycle); if they do, the word write wins.
module gpio_rf_latch
    import gpio_rf_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  wop_e                   op,
    input  logic [W-1:0]           wdata,
    input  logic                   bit_en,
    input  logic [$clog2(W)-1:0]   bit_idx,
    input  logic                   bit_val,
    output logic [W-1:0]           q
);
    logic [W-1:0] nxt;

    // Next-value selection for word writes and single-bit loads.
    always_comb begin
        nxt = q;
        if (wr_en) begin
            unique case (op)
                OP_SET:  nxt = q | wdata;
                OP_CLR:  nxt = q & ~wdata;
                default: nxt = wdata;
            endcase
        end else if (bit_en) begin
            nxt[bit_idx] = bit_val;
        end
    end

    // Latch register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // R2 / R4: a replace write loads the data word.
    assert_replace_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_REPLACE) |=> (q == $past(wdata)));
    // R3 / R4: a set write leaves every data bit at 1.
    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));
    // R3 / R4: a clear write leaves every data bit at 0 and others untouched.
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLR) |=> (((q & $past(wdata)) == '0) &&
                                     ((q | $past(wdata)) == ($past(q) | $past(wdata)))));
    // R6: a bit load sets exactly the addressed bit.
    assert_bit_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !wr_en) |=> (q[$past(bit_idx)] == $past(bit_val)));
endmodule

// File: rtl/gpio_rf_cfg_bank.sv
// Per-pin configuration words. Stores bits above bit 0 for each pin;
// bit 0 of each word is taken from the shared direction latch, so the
// two views of a pin's direction cannot disagree.
// Assumes the caller steers bit 0 of a configuration write into the
// direction latch in the same cycle.
module gpio_rf_cfg_bank
    import gpio_rf_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(NPINS)-1:0]           wr_idx,
    input  logic [DATA_W-1:1]                  wr_hi,
    input  logic [NPINS-1:0]                   dir_bits,
    output logic [NPINS-1:0][DATA_W-1:0]       words
);
    localparam logic [DATA_W-1:1] HI_RESET = CFG_RESET[DATA_W-1:1];

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [DATA_W-1:1] hi_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == i[$clog2(NPINS)-1:0]);

        // Upper configuration bits for pin i.
        always_ff @(posedge clk) begin
            if (!rst_n)   hi_q <= HI_RESET;
            else if (sel) hi_q <= wr_hi;
        end

        assign words[i] = {hi_q, dir_bits[i]};

        // R6: a write to this pin's word is visible after the edge.
        assert_cfg_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
            sel |=> (words[i][DATA_W-1:1] == $past(wr_hi)));
    end
endmodule

// File: rtl/gpio_port_regs.sv
// GPIO port register file top. Decodes single-word bus requests,
// updates the output and direction latches and the configuration
// words, samples the resolved pad input each cycle and returns read
// data one cycle after a read request.
// Assumes at most one request per cycle and no back-pressure.
module gpio_port_regs
    import gpio_rf_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [11:0]               req_addr,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic [31:0]               rsp_rdata,
    output logic                      bad_access,
    input  logic [31:0]               pad_in,
    output logic [31:0]               pad_out,
    output logic [31:0]               pad_dir,
    output logic [NPINS*32-1:0]       pad_cfg
);
    localparam int unsigned PIDX_W = $clog2(NPINS);

    tgt_e                        tgt;
    wop_e                        op;
    logic [PIDX_W-1:0]           pidx;
    logic                        hit;
    logic                        wr_out, wr_dir, wr_cfg;
    logic [NPINS-1:0]            out_q, dir_q;
    logic [DATA_W-1:0]           in_q;
    logic [NPINS-1:0][DATA_W-1:0] cfg_words;
    logic [DATA_W-1:0]           rd_mux;

    gpio_rf_decode #(.NPINS(NPINS)) u_decode (
        .addr (req_addr),
        .tgt  (tgt),
        .op   (op),
        .pidx (pidx),
        .hit  (hit)
    );

    assign wr_out = req_valid && req_write && (tgt == TGT_OUT);
    assign wr_dir = req_valid && req_write && (tgt == TGT_DIR);
    assign wr_cfg = req_valid && req_write && (tgt == TGT_CFG);

    gpio_rf_latch #(.W(NPINS)) u_out_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_out),
        .op      (op),
        .wdata   (req_wdata[NPINS-1:0]),
        .bit_en  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .q       (out_q)
    );

    gpio_rf_latch #(.W(NPINS)) u_dir_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_dir),
        .op      (op),
        .wdata   (req_wdata[NPINS-1:0]),
        .bit_en  (wr_cfg),
        .bit_idx (pidx),
        .bit_val (req_wdata[0]),
        .q       (dir_q)
    );

    gpio_rf_cfg_bank #(.NPINS(NPINS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cfg),
        .wr_idx   (pidx),
        .wr_hi    (req_wdata[DATA_W-1:1]),
        .dir_bits (dir_q),
        .words    (cfg_words)
    );

    // Sample the resolved pad input word on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= pad_in;
    end

    // Read data selection from the decoded target.
    always_comb begin
        unique case (tgt)
            TGT_OUT: rd_mux = DATA_W'(out_q);
            TGT_IN:  rd_mux = in_q;
            TGT_DIR: rd_mux = DATA_W'(dir_q);
            TGT_CFG: rd_mux = cfg_words[pidx];
            default: rd_mux = '0;
        endcase
    end

    // Registered response and bad-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            bad_access <= 1'b0;
        end else begin
            rsp_valid  <= req_valid && !req_write;
            rsp_rdata  <= (req_valid && !req_write) ? rd_mux : '0;
            bad_access <= req_valid && !hit;
        end
    end

    assign pad_out = out_q;
    assign pad_dir = dir_q;
    assign pad_cfg = cfg_words;

    // R8: a bad access leaves all pad-facing state unchanged.
    assert_bad_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> ($stable(pad_out) && $stable(pad_dir) && $stable(pad_cfg)));
    // R9: a response only follows a read request.
    assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
    // R6: a configuration write moves its bit 0 into the direction latch.
    assert_cfg_dir_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && tgt == TGT_CFG) |=> (pad_dir[$past(pidx)] == $past(req_wdata[0])));
    // R5: a direction alias write is reflected in bit 0 of the addressed words.
    assert_dir_reflect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && tgt == TGT_DIR) |=> (pad_cfg[0] == pad_dir[0]));
endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          bad_access;
    logic [31:0]   pad_in = '0;
    logic [31:0]   pad_out;
    logic [31:0]   pad_dir;
    logic [1023:0] pad_cfg;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_out = '0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_cfg [32];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    gpio_port_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .bad_access (bad_access),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_dir    (pad_dir),
        .pad_cfg    (pad_cfg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of a read: offsets taken from the requirements.
    function automatic logic [31:0] model_read(input logic [11:0] a);
        if (a == 12'h504 || a == 12'h508 || a == 12'h50C) return m_out;
        if (a == 12'h514 || a == 12'h518 || a == 12'h51C) return m_dir;
        if (a >= 12'h700 && a <= 12'h77C && a[1:0] == 2'b00)
            return {m_cfg[(a - 12'h700) >> 2][31:1], m_dir[(a - 12'h700) >> 2]};
        return 32'h0;
    endfunction

    // Reference model of a write.
    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h504: m_out = d;
            12'h508: m_out = m_out | d;
            12'h50C: m_out = m_out & ~d;
            12'h514: m_dir = d;
            12'h518: m_dir = m_dir | d;
            12'h51C: m_dir = m_dir & ~d;
            default: begin
                if (a >= 12'h700 && a <= 12'h77C && a[1:0] == 2'b00) begin
                    m_cfg[(a - 12'h700) >> 2] = d;
                    m_dir[(a - 12'h700) >> 2] = d[0];
                end
            end
        endcase
    endtask

    // Driver: one bus request, called at a falling edge, returns at the next.
    task automatic bus(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input bit use_exp, input logic [31:0] exp, input string tag);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (wr) model_write(a, d);
        else begin
            exp_q.push_back(use_exp ? exp : model_read(a));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) check("R9 write gives no response", {31'b0, rsp_valid}, 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus(1'b1, a, d, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        bus(1'b0, a, '0, 1'b0, '0, tag);
    endtask

    // Monitor: pop the scoreboard on every response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected response", 32'h1, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rsp_rdata, e);
            end
        end
    end

    task automatic check_pads(input string tag);
        check({tag, " pad_out"}, pad_out, m_out);
        check({tag, " pad_dir"}, pad_dir, m_dir);
        for (int i = 0; i < 32; i++)
            check({tag, " pad_cfg"}, pad_cfg[i*32 +: 32], {m_cfg[i][31:1], m_dir[i]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_cfg[i] = 32'h0000_0002;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(12'h504, "R1 out reset");
        rd(12'h514, "R1 dir reset");
        bus(1'b0, 12'h510, '0, 1'b1, 32'h0, "R1 in reset");
        rd(12'h700, "R1 cfg0 reset");
        rd(12'h77C, "R1 cfg31 reset");
        check("R1 bad_access idle", {31'b0, bad_access}, 32'h0);
        check_pads("R10 reset");

        // R2: replace and aliased reads
        wr(12'h504, 32'hA5A5_0F0F);
        check_pads("R10 after out write");
        rd(12'h504, "R2 read out");
        rd(12'h508, "R2 read outset");
        rd(12'h50C, "R2 read outclr");

        // R3: set and clear aliases, back to back with reads
        wr(12'h508, 32'h0000_F0F0);
        rd(12'h504, "R3 after set");
        wr(12'h50C, 32'hA000_000F);
        rd(12'h504, "R3 after clear");
        check("R3 model value", m_out, 32'h05A5_FFF0);

        // R4 / R5: direction aliases and mirroring into config words
        wr(12'h514, 32'h0000_00FF);
        rd(12'h514, "R4 read dir");
        rd(12'h518, "R4 read dirset");
        rd(12'h51C, "R4 read dirclr");
        rd(12'h70C, "R5 cfg3 bit0 after dir write");
        wr(12'h518, 32'h8000_0000);
        wr(12'h51C, 32'h0000_0001);
        rd(12'h514, "R4 dir after set and clear");
        check("R4 model value", m_dir, 32'h8000_00FE);
        rd(12'h700, "R5 cfg0 after dirclr");
        rd(12'h77C, "R5 cfg31 after dirset");
        check_pads("R10 after dir writes");

        // R6: config writes drive the direction bit
        wr(12'h714, 32'hDEAD_0700);
        rd(12'h514, "R6 dir bit5 cleared by cfg");
        rd(12'h714, "R6 cfg5 readback");
        wr(12'h750, 32'h0000_0301);
        rd(12'h514, "R6 dir bit20 set by cfg");
        rd(12'h750, "R6 cfg20 readback");
        wr(12'h518, 32'h0000_0020);
        rd(12'h714, "R5 cfg5 bit0 set by dirset");
        check_pads("R10 after cfg writes");

        // R7: input sampling against a same-cycle read
        pad_in = 32'h1234_5678;
        @(negedge clk);
        pad_in = 32'hCAFE_0001;
        bus(1'b0, 12'h510, '0, 1'b1, 32'h1234_5678, "R7 read sees previous sample");
        bus(1'b0, 12'h510, '0, 1'b1, 32'hCAFE_0001, "R7 read sees new sample");
        wr(12'h510, 32'hFFFF_FFFF);
        check("R7 write to input not bad", {31'b0, bad_access}, 32'h0);
        bus(1'b0, 12'h510, '0, 1'b1, 32'hCAFE_0001, "R7 write to input ignored");

        // R8: unmapped and misaligned accesses
        rd(12'h500, "R8 unmapped read is zero");
        check("R8 bad pulse on read", {31'b0, bad_access}, 32'h1);
        wr(12'h600, 32'hFFFF_FFFF);
        check("R8 bad pulse on write", {31'b0, bad_access}, 32'h1);
        rd(12'h504, "R8 out unchanged after unmapped write");
        check("R8 bad pulse lasts one cycle", {31'b0, bad_access}, 32'h0);
        wr(12'h505, 32'hFFFF_FFFF);
        check("R8 misaligned write bad", {31'b0, bad_access}, 32'h1);
        wr(12'h702, 32'hFFFF_FFFF);
        check("R8 misaligned cfg write bad", {31'b0, bad_access}, 32'h1);
        rd(12'h780, "R8 past last cfg word reads zero");
        check("R8 past last cfg word bad", {31'b0, bad_access}, 32'h1);
        check_pads("R8 state unchanged");

        repeat (3) @(negedge clk);
        check("R9 all reads answered", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule